// File: doc/BRIEF.md
# Selectable Divide-by-One/Two Clock Gate

This block takes a clock or data stream and either passes it through unchanged or halves its rate. It drives a true output and a complement output. An enable gates both outputs. A two-bit enable mode sets the active level of the enable and the level it takes when nothing drives it. When the block is disabled, the true and complement outputs are both low, not complementary. This lets the outputs of several instances be ORed onto shared lines: the one enabled unit sets the line, and the line is low when no unit is enabled.

The source is sampled on a system clock. In divide-by-two mode, a toggle bit flips on every sampled rising edge of the source. The same enable that gates the outputs also holds this toggle bit cleared. The first rising edge after the block is enabled therefore always drives the true output high. A separate floating flag stands in for an unconnected enable pin. When the flag is set, the mode's default replaces the enable level.

Top module: `clkgate_div12`

## Requirements
- R1: With `div2_sel` = 0 the block passes the source through. With `div2_sel` = 1 it drives the divided toggle state.
- R2: In pass-through mode, while enabled, `q_out` equals `src_in` and `qn_out` equals its inverse, in the same cycle and without a register.
- R3: Mode code 2'b00 makes the enable active high. With `en_float` set, the block is enabled.
- R4: Mode code 2'b01 makes the enable active high. With `en_float` set, the block is disabled.
- R5: Mode code 2'b10 makes the enable active low (the block is enabled when `en_level` = 0). With `en_float` set, the block is enabled.
- R6: Mode code 2'b11 behaves exactly like code 2'b00.
- R7: While the block is disabled, `q_out` and `qn_out` are both 0 in either divide mode.
- R8: In divide-by-two mode, the toggle state inverts at every clock edge where `src_in` is 1 and its previous sample was 0. While enabled, `q_out` shows the state and `qn_out` shows its inverse from the cycle after that edge.
- R9: The toggle state is cleared at every clock edge where the block is disabled or `rst_n` is low. The first sampled rising edge after enabling therefore makes `q_out` 1.
- R10: When the outputs of several instances are ORed, the result equals the outputs of the single enabled instance. When all instances are disabled, the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 1 | Clock or data source |
| div2_sel | input | 1 | 1 selects divide by two, 0 selects pass-through |
| en_mode | input | 2 | Enable polarity and floating-default code |
| en_level | input | 1 | Driven enable level |
| en_float | input | 1 | Enable pin left unconnected; the mode default applies |
| q_out | output | 1 | True output, low when disabled |
| qn_out | output | 1 | Complement output, low when disabled |

## Verification
A seeded random stream changes the source, the divide select, the mode, the level and the floating flag together. This separates the three polarity and default decodes, including the spare code, from each other and from the output gating. Directed runs hold the source as a steady square wave. They enable the block midway through a high phase and midway through a low phase. This shows whether the cleared toggle bit waits for a true rising edge rather than reacting to the level already present. A second, disabled instance is ORed with the first. This shows whether a disabled unit ever disturbs the shared lines.

// File: rtl/clkgate_div12_pkg.sv
package clkgate_div12_pkg;

   localparam int ENM_W = 2;

   typedef enum logic [ENM_W-1:0] {
      ENM_HI_DEF_ON  = 2'b00,
      ENM_HI_DEF_OFF = 2'b01,
      ENM_LO_DEF_ON  = 2'b10,
      ENM_SPARE      = 2'b11
   } en_mode_e;

   function automatic logic resolve_enable(input logic [ENM_W-1:0] mode,
                                           input logic lvl,
                                           input logic flt);
      logic r;
      case (en_mode_e'(mode))
         ENM_HI_DEF_OFF: r = flt ? 1'b0 : lvl;
         ENM_LO_DEF_ON:  r = flt ? 1'b1 : ~lvl;
         default:        r = flt ? 1'b1 : lvl;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ckg_enable_decode.sv
module ckg_enable_decode
   import clkgate_div12_pkg::*;
(
   input  logic [ENM_W-1:0] mode,
   input  logic             lvl,
   input  logic             flt,
   output logic             en_eff
);
   always_comb en_eff = resolve_enable(mode, lvl, flt);
endmodule

// File: rtl/ckg_toggle_div.sv
module ckg_toggle_div #(
   parameter int RESET_STATE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic run,
   output logic state
);
   initial begin
      if (RESET_STATE != 0 && RESET_STATE != 1)
         $error("RESET_STATE must be 0 or 1");
   end

   localparam logic RST_V = (RESET_STATE == 1);

   logic src_prev;
   logic rise;

   always_comb rise = src & ~src_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) src_prev <= 1'b0;
      else        src_prev <= src;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) state <= RST_V;
      else if (rise)      state <= ~state;
   end

   assert_cleared_when_off_R9: assert property (@(posedge clk)
      disable iff (!rst_n) !run |=> (state == RST_V));

   assert_toggle_on_rise_R8: assert property (@(posedge clk)
      disable iff (!rst_n) (run && rise) |=> (state != $past(state)));

   assert_hold_without_rise_R8: assert property (@(posedge clk)
      disable iff (!rst_n) (run && !rise) |=> $stable(state));
endmodule

// File: rtl/ckg_out_gate.sv
module ckg_out_gate #(
   parameter int DIV2_LEVEL = 1
) (
   input  logic div_sel,
   input  logic src,
   input  logic tog,
   input  logic en,
   output logic q,
   output logic qn
);
   initial begin
      if (DIV2_LEVEL != 0 && DIV2_LEVEL != 1)
         $error("DIV2_LEVEL must be 0 or 1");
   end

   logic pick;

   generate
      if (DIV2_LEVEL == 1) begin : g_sel_high
         always_comb pick = div_sel ? tog : src;
      end else begin : g_sel_low
         always_comb pick = div_sel ? src : tog;
      end
   endgenerate

   always_comb begin
      q  = en &  pick;
      qn = en & ~pick;
   end
endmodule

// File: rtl/clkgate_div12.sv
module clkgate_div12
   import clkgate_div12_pkg::*;
#(
   parameter int DIV2_LEVEL  = 1,
   parameter int RESET_STATE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_in,
   input  logic             div2_sel,
   input  logic [ENM_W-1:0] en_mode,
   input  logic             en_level,
   input  logic             en_float,
   output logic             q_out,
   output logic             qn_out
);
   logic en_eff;
   logic tog;
   logic div2_active;

   always_comb div2_active = (DIV2_LEVEL == 1) ? div2_sel : ~div2_sel;

   ckg_enable_decode u_dec (
      .mode   (en_mode),
      .lvl    (en_level),
      .flt    (en_float),
      .en_eff (en_eff)
   );

   ckg_toggle_div #(.RESET_STATE(RESET_STATE)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src_in),
      .run   (en_eff),
      .state (tog)
   );

   ckg_out_gate #(.DIV2_LEVEL(DIV2_LEVEL)) u_gate (
      .div_sel (div2_sel),
      .src     (src_in),
      .tog     (tog),
      .en      (en_eff),
      .q       (q_out),
      .qn      (qn_out)
   );

   assert_off_low_R7: assert property (@(posedge clk)
      disable iff (!rst_n) !en_eff |-> (!q_out && !qn_out));

   assert_pass_follow_R2: assert property (@(posedge clk)
      disable iff (!rst_n) (en_eff && !div2_active) |-> (q_out == src_in && qn_out == !src_in));

   assert_div_follow_R1: assert property (@(posedge clk)
      disable iff (!rst_n) (en_eff && div2_active) |-> (q_out == tog && qn_out == !tog));

   assert_float_off_R4: assert property (@(posedge clk)
      disable iff (!rst_n) (en_mode == 2'b01 && en_float) |-> !en_eff);

   assert_float_on_R5: assert property (@(posedge clk)
      disable iff (!rst_n) (en_mode != 2'b01 && en_float) |-> en_eff);

   assert_one_hot_out_R10: assert property (@(posedge clk)
      disable iff (!rst_n) $countones({q_out, qn_out}) == (en_eff ? 1 : 0));
endmodule

// File: tb/clkgate_div12_test.sv
module clkgate_div12_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       src_in, div2_sel, en_level, en_float;
   logic [1:0] en_mode;
   logic       q_out, qn_out;
   logic       b_q, b_qn;

   int n_chk = 0;
   int n_bad = 0;

   logic m_tog  = 1'b0;
   logic m_prev = 1'b0;

   always #4 clk = ~clk;

   clkgate_div12 uut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .div2_sel(div2_sel),
      .en_mode(en_mode), .en_level(en_level), .en_float(en_float),
      .q_out(q_out), .qn_out(qn_out));

   clkgate_div12 uut_b (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .div2_sel(~div2_sel),
      .en_mode(2'b01), .en_level(1'b0), .en_float(1'b1),
      .q_out(b_q), .qn_out(b_qn));

   function automatic logic exp_en(input logic [1:0] m, input logic l, input logic f);
      if (m == 2'b01)      return f ? 1'b0 : l;
      else if (m == 2'b10) return f ? 1'b1 : ~l;
      else                 return f ? 1'b1 : l;
   endfunction

   function automatic logic [1:0] exp_out(input logic en, input logic d2,
                                          input logic s, input logic t);
      logic p;
      p = d2 ? t : s;
      return en ? {p, ~p} : 2'b00;
   endfunction

   task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got q/qn=%b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   // drive at negedge, check combinational outputs, then advance the model at posedge
   task automatic step(input logic s, input logic d2, input logic [1:0] m,
                       input logic l, input logic f, input string tag);
      logic e;
      @(negedge clk);
      src_in = s; div2_sel = d2; en_mode = m; en_level = l; en_float = f;
      #1;
      e = exp_en(m, l, f);
      check(tag, {q_out, qn_out}, exp_out(e, d2, s, m_tog));
      check("R10", {q_out | b_q, qn_out | b_qn}, exp_out(e, d2, s, m_tog));
      @(posedge clk);
      if (!rst_n || !e)       m_tog = 1'b0;
      else if (s && !m_prev)  m_tog = ~m_tog;
      m_prev = rst_n ? s : 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      rst_n = 1'b0; src_in = 1'b0; div2_sel = 1'b1; en_mode = 2'b00;
      en_level = 1'b1; en_float = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset", {q_out, qn_out}, 2'b01);
      @(negedge clk);
      rst_n = 1'b1;
      m_tog = 1'b0; m_prev = 1'b0;

      // R3/R4/R5/R6 floating defaults and polarity, pass-through
      for (int m = 0; m < 4; m++) begin
         step(1'b1, 1'b0, 2'(m), 1'b0, 1'b1, "R3 R4 R5 R6 float");
         step(1'b0, 1'b0, 2'(m), 1'b1, 1'b0, "R3 R4 R5 R6 level hi");
         step(1'b1, 1'b0, 2'(m), 1'b0, 1'b0, "R3 R4 R5 R6 level lo");
      end
      // R2 pass-through square wave
      for (int i = 0; i < 8; i++) step(1'(i % 2), 1'b0, 2'b00, 1'b1, 1'b0, "R2");
      // R7 disabled in both divide modes
      for (int i = 0; i < 8; i++) step(1'(i % 2), 1'(i / 4), 2'b01, 1'b0, 1'b0, "R7");
      // R9 enable midway through a high phase: no edge until the next rise
      step(1'b1, 1'b1, 2'b10, 1'b1, 1'b0, "R9 off");
      step(1'b1, 1'b1, 2'b10, 1'b0, 1'b0, "R9 on high");
      step(1'b1, 1'b1, 2'b10, 1'b0, 1'b0, "R9 still high");
      step(1'b0, 1'b1, 2'b10, 1'b0, 1'b0, "R9 low");
      step(1'b1, 1'b1, 2'b10, 1'b0, 1'b0, "R9 rise");
      step(1'b1, 1'b1, 2'b10, 1'b0, 1'b0, "R9 first high");
      // R8 divide by two over a square wave
      for (int i = 0; i < 16; i++) step(1'(i % 2), 1'b1, 2'b11, 1'b1, 1'b0, "R8");
      // R9 enable during a low phase
      step(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, "R9 off low");
      step(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, "R9 on low");
      step(1'b1, 1'b1, 2'b00, 1'b1, 1'b0, "R9 rise2");
      step(1'b0, 1'b1, 2'b00, 1'b1, 1'b0, "R9 first high2");
      // R1 random mix of everything
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom(seed);
         seed = seed + 32'd7919;
         step(r[0], r[1], r[3:2], r[4] | r[5], r[6] & r[7], "R1 random");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule